// File: doc/BRIEF.md
# Prioritized Interrupt Request Recognizer

This block watches a three-wire, active-low interrupt priority bus and decides when a request should be handed to the processor core. It brings the wires into the clock domain and filters out short glitches. It turns the wires into a level from 0 to 7 and compares that level against a 3-bit priority mask. When a request qualifies, the block raises a pending flag and reports the level. The flag stays up until the core acknowledges it. On acknowledge, the mask is loaded with the serviced level, so that requests at that level or below are held off until software writes a lower mask.

Level 7 is the non-maskable level and is handled separately. It is recognized on every rise into 7 from any lower level, whatever the mask holds. Holding the request at 7 does not fire it again. A level-7 request is also recognized by plain comparison once software lowers the mask beneath 7 while the request sits at 7.

The controller has two states. `ST_IDLE` means nothing is pending, and `ST_PEND` means a request is latched. The named transitions are:
- **raise** (`ST_IDLE` to `ST_PEND`): a qualifying request arrives.
- **upgrade** (`ST_PEND` to `ST_PEND`): a higher request replaces the latched level.
- **service** (`ST_PEND` to `ST_IDLE`): an acknowledge arrives.
- **rearm** (`ST_PEND` to `ST_PEND`): an acknowledge arrives in the same cycle as a fresh level-7 rise.

Top module: `irq_recognizer`

## Requirements
- R1: The requested level is the bitwise inversion of `irq_pins_n`, with bit 0 as the least significant bit. All three wires high is level 0, which never raises an interrupt. For example, `3'b110` is level 1 and `3'b011` is level 4.
- R2: The wires pass through a two-stage synchronizer. A new level is used only after two consecutive synchronized samples agree. A level held for a single clock cycle is ignored. A level held steady is acted on by the fifth rising edge after it is applied.
- R3: A request at levels 1 to 6 raises `pend` only when the level is strictly greater than `mask`. A request equal to or below the mask produces nothing. This includes a request that falls below the mask and then returns to it.
- R4: A rise of the requested level from any lower value to 7 raises `pend` with `pend_lvl` = 7, whatever the mask holds. A request held at 7 does not raise a second interrupt.
- R5: While the request sits at 7, writing the mask to a value below 7 raises `pend` with `pend_lvl` = 7 by comparison.
- R6: `pend` and `pend_lvl` hold until `ack` is high on a clock edge. On that edge, `mask` loads `pend_lvl` and `pend` falls.
- R7: While an interrupt is pending, a higher qualifying request replaces `pend_lvl` before acknowledge.
- R8: Reset sets `mask` to 7 and clears `pend`. It also treats the previous level as 7, so the block sees no level-7 rise coming out of reset.
- R9: A write with `mask_wr` high loads `mask_wdata` on the next clock edge. An `ack` while nothing is pending leaves `mask` unchanged. When `ack` and `mask_wr` meet while an interrupt is pending, the acknowledge takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_pins_n | input | 3 | Active-low encoded interrupt priority wires |
| ack | input | 1 | Acknowledge of the pending interrupt |
| mask_wr | input | 1 | Software write strobe for the mask |
| mask_wdata | input | 3 | Mask value to write |
| mask | output | 3 | Current interrupt priority mask |
| pend | output | 1 | Interrupt pending |
| pend_lvl | output | 3 | Level of the pending interrupt |

## Verification
The bench targets the cases that separate a level compare from an edge detect:
- **Level 6 dip.** The request is dropped to 3 and raised back to 6 under mask 6. A design that treats level 6 as edge sensitive would raise a second interrupt here.
- **Level 7 dip.** The same dip is repeated under mask 7. A design that masks level 7, or detects no rise into it, stays silent.
- **Level 7 held.** The request is left at 7. A level-sensitive level 7 would fire repeatedly.
- **Mask lowered under a standing 7.** A design that only detects edges would miss this interrupt.

It also checks the following:
- **Glitch filter.** A one-cycle dip must be ignored, while a two-cycle dip must be honoured. A missing filter would fire on the glitch.
- **Upgrade.** A higher request must replace a lower pending one. A design without upgrade would report the stale level.
- **Idle acknowledge.** An acknowledge with nothing pending must leave the mask unchanged. A corrupted mask shows up in the value read back after the pulse.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int LVL_W = 3;
    typedef logic [LVL_W-1:0] lvl_t;
    localparam lvl_t LVL_TOP = '1;
    typedef enum logic {ST_IDLE, ST_PEND} rec_state_e;
endpackage

// File: rtl/irq_input_filter.sv
// Synchronizes the active-low priority wires and accepts a new level only
// after two consecutive synchronized samples agree.
module irq_input_filter
    import irq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  lvl_t pins_n,
    output lvl_t level
);
    lvl_t chain [SYNC_STAGES];
    lvl_t samp_q;
    lvl_t level_q;
    lvl_t synced;

    genvar g;
    generate
        for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[g] <= '0;       // all wires low encodes level 7
                    else        chain[g] <= pins_n;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[g] <= '0;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign synced = chain[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            samp_q  <= '0;
            level_q <= LVL_TOP;
        end else begin
            samp_q <= synced;
            if (synced == samp_q) level_q <= ~synced;   // R1 inversion, R2 agreement
        end
    end

    assign level = level_q;
endmodule

// File: rtl/irq_level_eval.sv
// Detects a rise into the top level and compares the level against the mask.
module irq_level_eval
    import irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  lvl_t level,
    input  lvl_t mask,
    output logic top_rise,
    output logic above_mask
);
    lvl_t prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= LVL_TOP;   // R8: no rise seen out of reset
        else        prev_q <= level;
    end

    assign top_rise   = (level == LVL_TOP) && (prev_q != LVL_TOP);
    assign above_mask = (level > mask);

    // R4: a rise into the top level lasts exactly one cycle
    p_single_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        top_rise |=> !top_rise);
endmodule

// File: rtl/irq_pend_fsm.sv
// Pending/acknowledge controller that owns the priority mask.
module irq_pend_fsm
    import irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  lvl_t level,
    input  logic top_rise,
    input  logic above_mask,
    input  logic ack,
    input  logic mask_wr,
    input  lvl_t mask_wdata,
    output lvl_t mask,
    output logic pend,
    output lvl_t pend_lvl
);
    rec_state_e state_q, state_d;
    lvl_t       lvl_q, lvl_d;
    lvl_t       mask_q, mask_d;
    logic       raise;

    assign raise = top_rise || above_mask;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            lvl_q   <= '0;
            mask_q  <= LVL_TOP;
        end else begin
            state_q <= state_d;
            lvl_q   <= lvl_d;
            mask_q  <= mask_d;
        end
    end

    always_comb begin
        state_d = state_q;
        lvl_d   = lvl_q;
        mask_d  = mask_q;
        unique case (state_q)
            ST_IDLE: begin
                if (mask_wr) mask_d = mask_wdata;
                if (raise) begin                // raise
                    state_d = ST_PEND;
                    lvl_d   = level;
                end
            end
            ST_PEND: begin
                if (ack) begin
                    mask_d = lvl_q;
                    if (top_rise) lvl_d = LVL_TOP;   // rearm
                    else          state_d = ST_IDLE; // service
                end else begin
                    if (mask_wr) mask_d = mask_wdata;
                    if (raise && (level > lvl_q)) lvl_d = level;  // upgrade
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign pend     = (state_q == ST_PEND);
    assign pend_lvl = lvl_q;
    assign mask     = mask_q;

    p_ack_loads_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PEND && ack) |=> (mask_q == $past(lvl_q)));
    p_hold_pending_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PEND && !ack) |=> (pend && lvl_q >= $past(lvl_q)));
    p_idle_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && ack && !mask_wr) |=> $stable(mask_q));
    p_pend_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pend |-> (lvl_q != '0));
endmodule

// File: rtl/irq_recognizer.sv
module irq_recognizer
    import irq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] irq_pins_n,
    input  logic       ack,
    input  logic       mask_wr,
    input  logic [2:0] mask_wdata,
    output logic [2:0] mask,
    output logic       pend,
    output logic [2:0] pend_lvl
);
    lvl_t level;
    logic top_rise;
    logic above_mask;

    irq_input_filter #(.SYNC_STAGES(SYNC_STAGES)) u_filter (
        .clk    (clk),
        .rst_n  (rst_n),
        .pins_n (irq_pins_n),
        .level  (level)
    );

    irq_level_eval u_eval (
        .clk        (clk),
        .rst_n      (rst_n),
        .level      (level),
        .mask       (mask),
        .top_rise   (top_rise),
        .above_mask (above_mask)
    );

    irq_pend_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .level      (level),
        .top_rise   (top_rise),
        .above_mask (above_mask),
        .ack        (ack),
        .mask_wr    (mask_wr),
        .mask_wdata (mask_wdata),
        .mask       (mask),
        .pend       (pend),
        .pend_lvl   (pend_lvl)
    );
endmodule

// File: tb/tb_irq_recognizer.sv
`timescale 1ns/1ps
module tb_irq_recognizer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] irq_pins_n = 3'b111;
    logic       ack = 1'b0;
    logic       mask_wr = 1'b0;
    logic [2:0] mask_wdata = 3'b000;
    logic [2:0] mask;
    logic       pend;
    logic [2:0] pend_lvl;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [2:0] exp_lvl[$];
    string      exp_tag[$];

    always #2.5 clk = ~clk;

    irq_recognizer dut (
        .clk(clk), .rst_n(rst_n), .irq_pins_n(irq_pins_n), .ack(ack),
        .mask_wr(mask_wr), .mask_wdata(mask_wdata),
        .mask(mask), .pend(pend), .pend_lvl(pend_lvl)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_level(input logic [2:0] l);
        @(negedge clk);
        irq_pins_n = ~l;
    endtask

    task automatic expect_irq(input logic [2:0] l, input string tag);
        exp_lvl.push_back(l);
        exp_tag.push_back(tag);
    endtask

    task automatic write_mask(input logic [2:0] v, input string tag);
        @(negedge clk);
        mask_wr = 1'b1;
        mask_wdata = v;
        @(negedge clk);
        mask_wr = 1'b0;
        check(mask == v, tag, mask, v);
    endtask

    task automatic service(input logic [2:0] m, input string tag);
        @(negedge clk);
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        check(pend == 1'b0, tag, pend, 0);
        check(mask == m, tag, mask, m);
    endtask

    // Monitor: every new pending report or level change pops one expected item
    logic       pend_d = 1'b0;
    logic [2:0] last_lvl = 3'b000;
    always @(negedge clk) begin
        if (rst_n && pend && (!pend_d || pend_lvl != last_lvl)) begin
            if (exp_lvl.size() == 0) begin
                check(1'b0, "R3_R4 unexpected interrupt", pend_lvl, 0);
            end else begin
                logic [2:0] e;
                string      t;
                e = exp_lvl.pop_front();
                t = exp_tag.pop_front();
                check(pend_lvl == e, t, pend_lvl, e);
            end
        end
        pend_d = pend;
        last_lvl = pend_lvl;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            check(1'b0, "watchdog", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        cycles(3);
        check(mask == 3'd7, "R8 reset mask", mask, 7);
        check(pend == 1'b0, "R8 reset pend", pend, 0);
        rst_n = 1'b1;
        cycles(8);
        check(pend == 1'b0, "R8 no rise from reset", pend, 0);

        // R3: level 3 under mask 7 is blocked
        set_level(3'd3);
        cycles(8);
        check(pend == 1'b0, "R3 blocked by mask", pend, 0);

        expect_irq(3'd3, "R3 level above mask");
        write_mask(3'd0, "R9 mask write");
        cycles(10);
        check(pend == 1'b1 && pend_lvl == 3'd3, "R6 held until ack", pend_lvl, 3);
        service(3'd3, "R6 ack loads mask");

        expect_irq(3'd5, "R3 level 5 above mask 3");
        set_level(3'd5);
        cycles(8);
        service(3'd5, "R6 ack loads mask 5");

        // R7: upgrade of a pending level
        set_level(3'd2);
        cycles(8);
        check(pend == 1'b0, "R3 below mask", pend, 0);
        expect_irq(3'd2, "R9 lowered mask admits 2");
        write_mask(3'd1, "R9 mask write");
        cycles(4);
        expect_irq(3'd6, "R7 upgrade to 6");
        set_level(3'd6);
        cycles(8);
        service(3'd6, "R7 mask after upgrade");

        // R3: dip to 3 and back to 6 under mask 6
        set_level(3'd3);
        cycles(8);
        set_level(3'd6);
        cycles(8);
        check(pend == 1'b0, "R3 level 6 dip ignored", pend, 0);

        // R4: rise into 7
        expect_irq(3'd7, "R4 rise into 7");
        set_level(3'd7);
        cycles(8);
        service(3'd7, "R4 mask 7");
        cycles(10);
        check(pend == 1'b0, "R4 held 7 no repeat", pend, 0);
        set_level(3'd3);
        cycles(8);
        expect_irq(3'd7, "R4 second rise into 7");
        set_level(3'd7);
        cycles(8);
        service(3'd7, "R4 mask 7 again");

        // R5: lowering the mask under a standing 7
        expect_irq(3'd7, "R5 mask lowered under 7");
        write_mask(3'd4, "R9 mask write 4");
        cycles(4);
        service(3'd7, "R5 mask back to 7");

        // R2: one-cycle dip is filtered
        set_level(3'd3);
        set_level(3'd7);
        cycles(10);
        check(pend == 1'b0, "R2 glitch rejected", pend, 0);
        // R2: two-cycle dip is accepted, then rise into 7
        expect_irq(3'd7, "R2 two-cycle dip accepted");
        set_level(3'd3);
        cycles(2);
        irq_pins_n = ~3'd7;
        cycles(10);
        service(3'd7, "R2 mask");

        // R9: ack with nothing pending
        @(negedge clk);
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        check(mask == 3'd7, "R9 idle ack no effect", mask, 7);

        // R1: decoding
        set_level(3'd0);
        cycles(8);
        write_mask(3'd0, "R9 mask write 0");
        cycles(8);
        check(pend == 1'b0, "R1 level 0 no request", pend, 0);
        expect_irq(3'd1, "R1 pins 110 is level 1");
        @(negedge clk);
        irq_pins_n = 3'b110;
        cycles(8);
        service(3'd1, "R1 mask 1");
        expect_irq(3'd4, "R1 pins 011 is level 4");
        @(negedge clk);
        irq_pins_n = 3'b011;
        cycles(8);
        service(3'd4, "R1 mask 4");

        cycles(4);
        check(exp_lvl.size() == 0, "R7 expected interrupt never raised", exp_lvl.size(), 0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule